// File: doc/BRIEF.md
# Edge-Capturing Interrupt Message Controller

This block gathers a set of interrupt request lines (eleven by default) and turns each new assertion of an enabled line into one 32-bit write on a master write port, so that an interrupt reaches its target as a memory write. A set of registers, reached over a simple 32-bit register bus, holds the live line levels, a per-line enable mask, a per-line route bit, a sticky record of edges seen, two masked status views and two message-address registers.

The lines are synchronised and compared against their value one cycle earlier, so only a low-to-high transition counts as an event. Every event is recorded in the pending register. If the line's mask bit is set, the event also enters a request set. The request set is drained lowest line index first, one message per accepted handshake. The route bit of the line selects one of the two address registers. The message address is that register with its five low bits cleared. The message data word carries those five low bits in bits 4:0. The byte lane order of the word on the bus is left to the interconnect.

By default the lines carry these sources. Lines 0 to 5 are the PCI INTA to INTF pins. Line 6 is an external bus interrupt, line 7 a bus error, line 8 the PS2 port and line 10 the serial port. Line 9 is spare.

Top module: `irq_msg_ctrl`

## Requirements
- R1: Register word index 0 reads the synchronised line levels in bits NUM_SRC-1:0. A line going low clears only its own bit.
- R2: A low-to-high transition of a line sets its pending bit in register word 3. A line that stays high produces no further event.
- R3: A read of word 3 returns the pending value and clears it. An edge arriving in the same cycle as the clear is kept.
- R4: Any write to word 3 clears the pending register, whatever the write data.
- R5: Word 4 reads level & mask & ~route. Word 5 reads level & mask & route. The mask is word 1 and the route is word 2.
- R6: Each rising edge of a line whose mask bit is 1 yields exactly one message. A rising edge with mask bit 0 yields none, but it still sets the pending bit.
- R7: The message uses address word 7 when the line's route bit is 1, and word 6 otherwise. msg_addr is the chosen word with bits 4:0 cleared. msg_data holds the chosen word's bits 4:0, with bits 31:5 zero.
- R8: Lines that rise in the same cycle are sent as separate messages, in ascending line index.
- R9: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold steady.
- R10: Writes to words 0, 4 and 5 change nothing.
- R11: After reset, msg_valid is 0, and mask, route, pending and both address words read 0. Read data appears on reg_rdata in the cycle after reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_SRC | Asynchronous interrupt request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The assertions check, on every cycle, that an offered message stays frozen while the port is stalled and that message addresses are aligned with narrow data words. They also check that a read or write of the pending word leaves only bits set by new edges. Which lines produce messages, in what order and to which address, which lines are suppressed by the mask, and how the status views split across the two routes, can only be shown by the bench. It does this by raising chosen line patterns under chosen mask and route settings and collecting the messages at the port.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

    localparam int unsigned REG_DW      = 32;
    localparam int unsigned REG_AW      = 3;
    localparam int unsigned MSG_LOW_W   = 5;

    typedef enum logic [REG_AW-1:0] {
        SEL_LEVEL = 3'd0,
        SEL_MASK  = 3'd1,
        SEL_ROUTE = 3'd2,
        SEL_PEND  = 3'd3,
        SEL_STAT0 = 3'd4,
        SEL_STAT1 = 3'd5,
        SEL_ADDR0 = 3'd6,
        SEL_ADDR1 = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int unsigned N           = 11,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] level,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    generate
        if (SYNC_STAGES <= 1) begin : g_single
            logic [N-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= din;
            end
            assign level = stage_q;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0][N-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[SYNC_STAGES-2:0], din};
            end
            assign level = stage_q[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest #(
    parameter int unsigned N = 11
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
        any = found;
    end
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
    import irq_msg_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 11,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [31:0] ADDR_RST    = 32'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [31:0]        msg_addr,
    output logic [31:0]        msg_data
);
    localparam logic [31:0] LOW_MASK = (32'h1 << MSG_LOW_W) - 32'h1;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] route;
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] send;
        logic [31:0]        addr0;
        logic [31:0]        addr1;
        logic [31:0]        rdata;
        logic               mvalid;
        logic [31:0]        maddr;
        logic [31:0]        mdata;
    } state_t;

    localparam state_t RESET_STATE = '{
        mask:   '0,
        route:  '0,
        pend:   '0,
        send:   '0,
        addr0:  ADDR_RST,
        addr1:  ADDR_RST,
        rdata:  '0,
        mvalid: 1'b0,
        maddr:  '0,
        mdata:  '0
    };

    state_t r_d, r_q;

    logic [NUM_SRC-1:0] level_w;
    logic [NUM_SRC-1:0] rise_w;
    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] grant_w;
    logic               grant_any;

    irq_edge_detect #(
        .N           (NUM_SRC),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_in),
        .level (level_w),
        .rise  (rise_w)
    );

    irq_pick_lowest #(
        .N (NUM_SRC)
    ) i_pick (
        .req   (r_q.send),
        .grant (grant_w),
        .any   (grant_any)
    );

    function automatic logic [31:0] widen(input logic [NUM_SRC-1:0] v);
        logic [31:0] w;
        w = '0;
        w[NUM_SRC-1:0] = v;
        return w;
    endfunction

    always_comb begin
        reg_sel_e    sel;
        logic        pend_clr;
        logic        load;
        logic [31:0] chosen;
        logic [31:0] rd_mux;

        r_d      = r_q;
        sel      = reg_sel_e'(reg_addr);
        pend_clr = (reg_rd || reg_wr) && (sel == SEL_PEND);

        // Sticky edge record, cleared by any access to it.
        r_d.pend = (pend_clr ? '0 : r_q.pend) | rise_w;

        // Enabled edges join the request set.
        r_d.send = r_q.send | (rise_w & r_q.mask);

        if (reg_wr) begin
            unique case (sel)
                SEL_MASK:  r_d.mask  = reg_wdata[NUM_SRC-1:0];
                SEL_ROUTE: r_d.route = reg_wdata[NUM_SRC-1:0];
                SEL_ADDR0: r_d.addr0 = reg_wdata;
                SEL_ADDR1: r_d.addr1 = reg_wdata;
                default:   ;
            endcase
        end

        unique case (sel)
            SEL_LEVEL: rd_mux = widen(level_w);
            SEL_MASK:  rd_mux = widen(r_q.mask);
            SEL_ROUTE: rd_mux = widen(r_q.route);
            SEL_PEND:  rd_mux = widen(r_q.pend);
            SEL_STAT0: rd_mux = widen(level_w & r_q.mask & ~r_q.route);
            SEL_STAT1: rd_mux = widen(level_w & r_q.mask & r_q.route);
            SEL_ADDR0: rd_mux = r_q.addr0;
            default:   rd_mux = r_q.addr1;
        endcase
        if (reg_rd) r_d.rdata = rd_mux;

        // Message stage: refill when empty or when the current one is taken.
        chosen = ((grant_w & r_q.route) != '0) ? r_q.addr1 : r_q.addr0;
        load   = !r_q.mvalid || msg_ready;
        if (load) begin
            r_d.mvalid = grant_any;
            if (grant_any) begin
                r_d.send  = r_d.send & ~grant_w;
                r_d.maddr = chosen & ~LOW_MASK;
                r_d.mdata = chosen & LOW_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_STATE;
        else        r_q <= r_d;
    end

    assign pend_w    = r_q.pend;
    assign reg_rdata = r_q.rdata;
    assign msg_valid = r_q.mvalid;
    assign msg_addr  = r_q.maddr;
    assign msg_data  = r_q.mdata;
endmodule

// File: rtl/irq_msg_chk.sv
module irq_msg_chk
    import irq_msg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_rd,
    input logic               reg_wr,
    input logic [2:0]         reg_addr,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [31:0]        msg_addr,
    input logic [31:0]        msg_data,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] rise
);
    // R9: stalled message is frozen
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R7: address aligned to the cleared low field
    a_r7_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[MSG_LOW_W-1:0] == '0));

    // R7: data carries only the low field
    a_r7_data_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_data[31:MSG_LOW_W] == '0));

    // R3: read of the pending word leaves only fresh edges
    a_r3_pend_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == SEL_PEND) |=> ((pend & ~$past(rise)) == '0));

    // R4: write of the pending word leaves only fresh edges
    a_r4_pend_wr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEL_PEND) |=> ((pend & ~$past(rise)) == '0));

    // R2: every edge is recorded
    a_r2_edge_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend & $past(rise)) == $past(rise)));
endmodule

bind irq_msg_ctrl irq_msg_chk #(.NUM_SRC(NUM_SRC)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .pend      (pend_w),
    .rise      (rise_w)
);

// File: tb/test_irq_msg_ctrl.sv
module test_irq_msg_ctrl;
    localparam int N = 11;
    localparam logic [31:0] A0 = 32'h1000_0043;
    localparam logic [31:0] A1 = 32'h2000_00BF;
    // {lines, mask, route}
    localparam logic [32:0] VEC [6] = '{
        {11'h001, 11'h7FF, 11'h000},
        {11'h7FF, 11'h7FF, 11'h555},
        {11'h400, 11'h3FF, 11'h000},
        {11'h0C3, 11'h0FF, 11'h0C0},
        {11'h2A5, 11'h7F0, 11'h7FF},
        {11'h500, 11'h7FF, 11'h100}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic msg_valid, msg_ready = 1'b1;
    logic [31:0] msg_addr, msg_data;

    int n_chk = 0, n_fail = 0;
    int mon_cnt = 0;
    logic [31:0] mon_addr [256];
    logic [31:0] mon_data [256];

    always #4 clk = ~clk;

    irq_msg_ctrl i_irq_msg_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            mon_addr[mon_cnt[7:0]] = msg_addr;
            mon_data[mon_cnt[7:0]] = msg_data;
            mon_cnt = mon_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_addr(input logic r);
        return (r ? A1 : A0) & 32'hFFFF_FFE0;
    endfunction

    function automatic logic [31:0] exp_data(input logic r);
        return (r ? A1 : A0) & 32'h1F;
    endfunction

    initial begin : wdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [N-1:0] lines, msk, rte;
        int base, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        check("R11 valid", {31'b0, msg_valid}, 32'h0);
        rd(3'd1, v); check("R11 mask", v, 32'h0);
        rd(3'd2, v); check("R11 route", v, 32'h0);
        rd(3'd3, v); check("R11 pend", v, 32'h0);
        rd(3'd6, v); check("R11 addr0", v, 32'h0);
        rd(3'd7, v); check("R11 addr1", v, 32'h0);
        rd(3'd0, v); check("R1 level reset", v, 32'h0);

        wr(3'd6, A0);
        wr(3'd7, A1);

        // Vector walk: R5 R6 R7 R8 R3
        for (int t = 0; t < 6; t++) begin
            lines = VEC[t][32:22]; msk = VEC[t][21:11]; rte = VEC[t][10:0];
            wr(3'd1, {21'b0, msk});
            wr(3'd2, {21'b0, rte});
            rd(3'd3, v);
            base = mon_cnt;
            irq_in = lines;
            idle(20);
            k = 0;
            for (int i = 0; i < N; i++) begin
                if (lines[i] && msk[i]) begin
                    check("R8 R7 addr", mon_addr[(base + k) % 256], exp_addr(rte[i]));
                    check("R7 data", mon_data[(base + k) % 256], exp_data(rte[i]));
                    k++;
                end
            end
            check("R6 message count", mon_cnt - base, k);
            rd(3'd0, v); check("R1 level", v, {21'b0, lines});
            rd(3'd4, v); check("R5 stat0", v, {21'b0, lines & msk & ~rte});
            rd(3'd5, v); check("R5 stat1", v, {21'b0, lines & msk & rte});
            rd(3'd3, v); check("R2 pend", v, {21'b0, lines});
            rd(3'd3, v); check("R3 pend cleared by read", v, 32'h0);
            irq_in = '0;
            idle(5);
            rd(3'd0, v); check("R1 level low", v, 32'h0);
        end

        // R2: a line already high makes no new event
        wr(3'd1, 32'h7FF); wr(3'd2, 32'h0);
        irq_in = 11'h004; idle(8);
        rd(3'd3, v);
        base = mon_cnt;
        irq_in = 11'h00C; idle(8);
        check("R2 one msg", mon_cnt - base, 1);
        rd(3'd3, v); check("R2 only new bit", v, 32'h8);

        // R1: falling line clears only its own bit
        irq_in = 11'h008; idle(5);
        rd(3'd0, v); check("R1 own bit", v, 32'h8);
        irq_in = '0; idle(5);

        // R4: write clears pending regardless of data
        irq_in = 11'h020; idle(6);
        wr(3'd3, 32'h0000_0000);
        rd(3'd3, v); check("R4 pend cleared", v, 32'h0);
        irq_in = 11'h040; idle(6);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, v); check("R4 pend cleared ones", v, 32'h0);
        irq_in = '0; idle(5);

        // R10: read-only words ignore writes
        irq_in = 11'h011; idle(8);
        wr(3'd0, 32'h7FF); wr(3'd4, 32'h7FF); wr(3'd5, 32'h7FF);
        rd(3'd0, v); check("R10 level", v, 32'h011);
        rd(3'd4, v); check("R10 stat0", v, 32'h011);
        rd(3'd5, v); check("R10 stat1", v, 32'h0);
        irq_in = '0; idle(5);

        // R9: hold under backpressure, then drain in order (R8)
        msg_ready = 1'b0;
        irq_in = 11'h284; idle(10);
        check("R9 valid", {31'b0, msg_valid}, 32'h1);
        check("R9 addr", msg_addr, exp_addr(1'b0));
        idle(3);
        check("R9 still valid", {31'b0, msg_valid}, 32'h1);
        check("R9 data", msg_data, exp_data(1'b0));
        base = mon_cnt;
        msg_ready = 1'b1;
        idle(8);
        check("R8 drained count", mon_cnt - base, 3);
        check("R9 valid low", {31'b0, msg_valid}, 32'h0);
        irq_in = '0; idle(4);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule